// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits beside a small processor core and decides, cycle by cycle, which parts of the system receive a clock or an enable. Software picks one of three sleep modes by writing two small control registers over a simple register bus. The first is a power register that holds an idle request and a stop request. The second is an oscillator register that holds a suspend request. The block turns these requests into clock-gate and enable outputs for the CPU, the peripherals, the timers, the interrupt logic, the internal oscillator and the missing-clock detector.

Idle halts only the CPU clock, and it does so only after the core reports that the instruction that wrote the request has retired. Any enabled interrupt ends Idle. Stop shuts down everything except the missing-clock detector, and only a reset ends it. Suspend turns off the internal oscillator while the CPU keeps running on another clock. A USB wake event ends Suspend, and the block then waits for the oscillator to report that it is ready. Every reset source clears the requests and drives a reset pulse of fixed length to the core, which then restarts from its reset vector.

Top module: `lpm_ctrl`

## Requirements
- R1: After bit 0 (idle) of the power register at address 0 is set, the mode stays Run and `cpu_clk_en` stays high until a cycle in which `instr_done` is high. On the clock edge that samples that cycle, the block enters Idle.
- R2: In Idle, `cpu_clk_en` is low and `periph_clk_en`, `timer_en`, `irq_en`, `intosc_en` and `mcd_en` are all high.
- R3: In Idle, a high on any bit of `irq_req` returns the block to Run on the next edge and clears the idle bit, so that a read of address 0 returns 0.
- R4: A low `rst_n`, `int_rst_req`, `mcd_rst`, or `wdt_rst` while `wdt_en` is high returns the block to Run and clears all request bits. After the edge that samples the reset, `cpu_rst` is high for RST_LEN cycles.
- R5: `wdt_rst` has no effect while `wdt_en` is low.
- R6: In Stop, `cpu_clk_en`, `periph_clk_en`, `timer_en`, `irq_en` and `intosc_en` are low and `mcd_en` stays high.
- R7: Stop is left only through a reset source. `irq_req`, `usb_wake` and `osc_ready` do not affect it.
- R8: `extosc_en` follows `extosc_req` in every mode.
- R9: Bit 7 (suspend) of the oscillator register at address 1 puts the block in Suspend. In Suspend, `intosc_en` is low and the CPU, peripheral, timer and interrupt enables stay high.
- R10: In Suspend, `usb_wake` (after SYNC_STAGES synchroniser flops) clears the suspend bit and raises `intosc_en`. The mode reads Suspend until an edge that samples `osc_ready` high, and then becomes Run.
- R11: A read of address 0 returns the idle bit in bit 0 and the stop bit in bit 1. If both bits are written as 1 in one write, only the stop bit is kept and Stop is entered.
- R12: `mode` encodes Run=0, Idle=1, Stop=2 and Suspend=3. Stop has priority over Suspend, and Suspend has priority over Idle.
- R13: Register writes are ignored unless the mode is Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the controller |
| rst_n | input | 1 | External asynchronous reset, active low |
| int_rst_req | input | 1 | Internal reset request |
| mcd_rst | input | 1 | Reset from the missing-clock detector |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_rst | input | 1 | Watchdog expiry |
| irq_req | input | N_IRQ | Enabled interrupt requests |
| instr_done | input | 1 | Strobe: current instruction retired |
| usb_wake | input | 1 | USB activity wake |
| osc_ready | input | 1 | Internal oscillator stable |
| extosc_req | input | 1 | Requested external oscillator enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| timer_en | output | 1 | Timer enable |
| irq_en | output | 1 | Interrupt logic enable |
| intosc_en | output | 1 | Internal oscillator enable |
| mcd_en | output | 1 | Missing-clock detector enable |
| extosc_en | output | 1 | External oscillator enable |
| cpu_rst | output | 1 | Reset pulse to the core |
| mode | output | 2 | Current power mode code |

## Verification
A corrupted sequencer state shows up on `mode` and on the gate outputs at the next sampling point after the edge that loaded it. No output sits behind an extra register stage. A request bit held with the wrong value shows up in two ways. A read of the register returns it at once. The mode then goes wrong one edge after the event that should have used the bit (a retired instruction, an interrupt or a wake). A reference model in the bench predicts every output on every cycle. Any such divergence is therefore reported in the same cycle, and not only at a later directed check.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   localparam int IDLE_BIT = 0;
   localparam int STOP_BIT = 1;

   typedef enum logic [2:0] {
      ST_RUN  = 3'd0,
      ST_IDLE = 3'd1,
      ST_STOP = 3'd2,
      ST_SUSP = 3'd3,
      ST_WAKE = 3'd4
   } lpm_state_e;

   typedef enum logic [1:0] {
      MD_RUN  = 2'd0,
      MD_IDLE = 2'd1,
      MD_STOP = 2'd2,
      MD_SUSP = 2'd3
   } lpm_mode_e;

   typedef struct packed {
      logic cpu;
      logic periph;
      logic timer;
      logic irq;
      logic intosc;
      logic mcd;
   } lpm_gates_t;

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
   import lpm_pkg::*;
#(
   parameter int AW       = 2,
   parameter int DW       = 8,
   parameter int PWR_ADDR = 0,
   parameter int OSC_ADDR = 1,
   parameter int SUSP_BIT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          accept,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          clr_idle,
   input  logic          clr_susp,
   output logic          idle_q,
   output logic          stop_q,
   output logic          susp_q,
   output logic [DW-1:0] rdata
);

   localparam logic [AW-1:0] PWR_A = AW'(PWR_ADDR);
   localparam logic [AW-1:0] OSC_A = AW'(OSC_ADDR);

   logic hit_pwr;
   logic hit_osc;

   assign hit_pwr = wr_en && accept && (addr == PWR_A);
   assign hit_osc = wr_en && accept && (addr == OSC_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= 1'b0;
         stop_q <= 1'b0;
      end else if (soft_rst) begin
         idle_q <= 1'b0;
         stop_q <= 1'b0;
      end else if (hit_pwr) begin
         stop_q <= wdata[STOP_BIT];
         idle_q <= wdata[IDLE_BIT] & ~wdata[STOP_BIT];
      end else if (clr_idle) begin
         idle_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         susp_q <= 1'b0;
      end else if (soft_rst) begin
         susp_q <= 1'b0;
      end else if (hit_osc) begin
         susp_q <= wdata[SUSP_BIT];
      end else if (clr_susp) begin
         susp_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == PWR_A) begin
         rdata[IDLE_BIT] = idle_q;
         rdata[STOP_BIT] = stop_q;
      end else if (addr == OSC_A) begin
         rdata[SUSP_BIT] = susp_q;
      end
   end

   AST_STOP_EXCL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(stop_q && idle_q)); // R11

   AST_HOLD_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept && !soft_rst && !clr_idle && !clr_susp)
      |=> $stable({idle_q, stop_q, susp_q})); // R13

endmodule

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_in,
   output logic wake_out
);

   generate
      if (STAGES == 0) begin : g_direct
         assign wake_out = wake_in;
      end else begin : g_flops
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= wake_in;
               for (int i = 1; i < STAGES; i++) begin
                  sh[i] <= sh[i-1];
               end
            end
         end
         assign wake_out = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
#(
   parameter int RST_LEN = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       any_rst,
   input  logic       idle_q,
   input  logic       stop_q,
   input  logic       susp_q,
   input  logic       instr_done,
   input  logic       irq_any,
   input  logic       wake,
   input  logic       osc_ready,
   output lpm_state_e state,
   output logic       clr_idle,
   output logic       clr_susp,
   output logic       cpu_rst
);

   localparam int CW = $clog2(RST_LEN + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(RST_LEN);

   lpm_state_e       nxt;
   logic [CW-1:0]    rcnt;

   always_comb begin
      nxt      = state;
      clr_idle = 1'b0;
      clr_susp = 1'b0;
      case (state)
         ST_RUN: begin
            if (stop_q)                    nxt = ST_STOP;
            else if (susp_q)               nxt = ST_SUSP;
            else if (idle_q && instr_done) nxt = ST_IDLE;
         end
         ST_IDLE: begin
            if (irq_any) begin
               nxt      = ST_RUN;
               clr_idle = 1'b1;
            end
         end
         ST_STOP: nxt = ST_STOP;
         ST_SUSP: begin
            if (wake) begin
               nxt      = ST_WAKE;
               clr_susp = 1'b1;
            end
         end
         ST_WAKE: begin
            if (osc_ready) nxt = ST_RUN;
         end
         default: nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_RUN;
         rcnt  <= CNT_LOAD;
      end else if (any_rst) begin
         state <= ST_RUN;
         rcnt  <= CNT_LOAD;
      end else begin
         state <= nxt;
         if (rcnt != '0) rcnt <= rcnt - 1'b1;
      end
   end

   assign cpu_rst = (rcnt != '0);

   AST_IDLE_WAITS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !instr_done) |=> (state != ST_IDLE)); // R1

   AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOP && !any_rst) |=> (state == ST_STOP)); // R7

   AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      any_rst |=> (cpu_rst && state == ST_RUN)); // R4

   AST_WAKE_WAITS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE && !osc_ready && !any_rst) |=> (state == ST_WAKE)); // R10

   AST_IDLE_EXIT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && irq_any && !any_rst) |=> (state == ST_RUN && !idle_q)); // R3

endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
   import lpm_pkg::*;
(
   input  lpm_state_e state,
   output lpm_gates_t gates,
   output lpm_mode_e  mode
);

   always_comb begin
      gates = '{cpu: 1'b1, periph: 1'b1, timer: 1'b1, irq: 1'b1, intosc: 1'b1, mcd: 1'b1};
      mode  = MD_RUN;
      case (state)
         ST_IDLE: begin
            gates.cpu = 1'b0;
            mode      = MD_IDLE;
         end
         ST_STOP: begin
            gates.cpu    = 1'b0;
            gates.periph = 1'b0;
            gates.timer  = 1'b0;
            gates.irq    = 1'b0;
            gates.intosc = 1'b0;
            mode         = MD_STOP;
         end
         ST_SUSP: begin
            gates.intosc = 1'b0;
            mode         = MD_SUSP;
         end
         ST_WAKE: begin
            mode = MD_SUSP;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int N_IRQ       = 4,
   parameter int AW          = 2,
   parameter int DW          = 8,
   parameter int PWR_ADDR    = 0,
   parameter int OSC_ADDR    = 1,
   parameter int SUSP_BIT    = 7,
   parameter int RST_LEN     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             int_rst_req,
   input  logic             mcd_rst,
   input  logic             wdt_en,
   input  logic             wdt_rst,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic             instr_done,
   input  logic             usb_wake,
   input  logic             osc_ready,
   input  logic             extosc_req,
   input  logic             reg_wr,
   input  logic [AW-1:0]    reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   output logic             cpu_clk_en,
   output logic             periph_clk_en,
   output logic             timer_en,
   output logic             irq_en,
   output logic             intosc_en,
   output logic             mcd_en,
   output logic             extosc_en,
   output logic             cpu_rst,
   output logic [1:0]       mode
);

   generate
      if (N_IRQ < 1) begin : g_chk_irq
         $error("N_IRQ must be at least 1");
      end
      if (DW < 2 || SUSP_BIT >= DW || SUSP_BIT < 2) begin : g_chk_dw
         $error("SUSP_BIT must lie in [2, DW-1]");
      end
      if (AW < 1 || PWR_ADDR == OSC_ADDR || PWR_ADDR >= (1 << AW) || OSC_ADDR >= (1 << AW)) begin : g_chk_addr
         $error("register addresses must be distinct and fit AW");
      end
      if (RST_LEN < 1) begin : g_chk_rst
         $error("RST_LEN must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 8) begin : g_chk_sync
         $error("SYNC_STAGES must lie in [0, 8]");
      end
   endgenerate

   lpm_state_e state;
   lpm_gates_t gates;
   lpm_mode_e  mode_e;
   logic       any_rst;
   logic       accept;
   logic       idle_q, stop_q, susp_q;
   logic       clr_idle, clr_susp;
   logic       wake_s;
   logic       irq_any;

   assign any_rst = int_rst_req | mcd_rst | (wdt_en & wdt_rst);
   assign accept  = (state == ST_RUN);
   assign irq_any = |irq_req;

   lpm_regs #(
      .AW       (AW),
      .DW       (DW),
      .PWR_ADDR (PWR_ADDR),
      .OSC_ADDR (OSC_ADDR),
      .SUSP_BIT (SUSP_BIT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (any_rst),
      .accept   (accept),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .clr_idle (clr_idle),
      .clr_susp (clr_susp),
      .idle_q   (idle_q),
      .stop_q   (stop_q),
      .susp_q   (susp_q),
      .rdata    (reg_rdata)
   );

   lpm_wake_sync #(
      .STAGES (SYNC_STAGES)
   ) u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .wake_in  (usb_wake),
      .wake_out (wake_s)
   );

   lpm_seq #(
      .RST_LEN (RST_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .any_rst    (any_rst),
      .idle_q     (idle_q),
      .stop_q     (stop_q),
      .susp_q     (susp_q),
      .instr_done (instr_done),
      .irq_any    (irq_any),
      .wake       (wake_s),
      .osc_ready  (osc_ready),
      .state      (state),
      .clr_idle   (clr_idle),
      .clr_susp   (clr_susp),
      .cpu_rst    (cpu_rst)
   );

   lpm_gate_dec u_dec (
      .state (state),
      .gates (gates),
      .mode  (mode_e)
   );

   assign cpu_clk_en    = gates.cpu;
   assign periph_clk_en = gates.periph;
   assign timer_en      = gates.timer;
   assign irq_en        = gates.irq;
   assign intosc_en     = gates.intosc;
   assign mcd_en        = gates.mcd;
   assign mode          = mode_e;
   assign extosc_en     = extosc_req;

   AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2) |-> (!cpu_clk_en && !irq_en && !timer_en && !intosc_en && mcd_en)); // R6

   AST_SUSP_CPU_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && !intosc_en) |-> (cpu_clk_en && periph_clk_en)); // R9

   AST_WDT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_rst && !wdt_en && !int_rst_req && !mcd_rst && mode == 2'd1 && irq_req == '0)
      |=> (mode == 2'd1)); // R5

endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;

   localparam int N_IRQ = 4;
   localparam int AW    = 2;
   localparam int DW    = 8;
   localparam int RSTL  = 4;
   localparam int STG   = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             int_rst_req = 1'b0, mcd_rst = 1'b0, wdt_en = 1'b0, wdt_rst = 1'b0;
   logic [N_IRQ-1:0] irq_req = '0;
   logic             instr_done = 1'b0, usb_wake = 1'b0, osc_ready = 1'b0, extosc_req = 1'b0;
   logic             reg_wr = 1'b0;
   logic [AW-1:0]    reg_addr = '0;
   logic [DW-1:0]    reg_wdata = '0;
   logic [DW-1:0]    reg_rdata;
   logic cpu_clk_en, periph_clk_en, timer_en, irq_en, intosc_en, mcd_en, extosc_en, cpu_rst;
   logic [1:0]       mode;

   int checks = 0;
   int failures = 0;
   bit started = 1'b0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   lpm_ctrl #(.N_IRQ(N_IRQ), .AW(AW), .DW(DW), .RST_LEN(RSTL), .SYNC_STAGES(STG)) u0 (
      .clk(clk), .rst_n(rst_n), .int_rst_req(int_rst_req), .mcd_rst(mcd_rst),
      .wdt_en(wdt_en), .wdt_rst(wdt_rst), .irq_req(irq_req), .instr_done(instr_done),
      .usb_wake(usb_wake), .osc_ready(osc_ready), .extosc_req(extosc_req),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .timer_en(timer_en),
      .irq_en(irq_en), .intosc_en(intosc_en), .mcd_en(mcd_en), .extosc_en(extosc_en),
      .cpu_rst(cpu_rst), .mode(mode)
   );

   // reference model: 0 run, 1 idle, 2 stop, 3 suspend, 4 waking
   int m_st = 0, m_idle = 0, m_stop = 0, m_susp = 0, m_rc = RSTL;
   logic [7:0] m_pipe = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_idle = 0; m_stop = 0; m_susp = 0; m_rc = RSTL; m_pipe = '0;
      end else begin
         int  ns, ni, nstop, nsu;
         bit  wk;
         wk = (STG == 0) ? usb_wake : m_pipe[STG-1];
         m_pipe = {m_pipe[6:0], usb_wake};
         if (int_rst_req || mcd_rst || (wdt_en && wdt_rst)) begin
            m_st = 0; m_idle = 0; m_stop = 0; m_susp = 0; m_rc = RSTL;
         end else begin
            ns = m_st; ni = m_idle; nstop = m_stop; nsu = m_susp;
            if (m_st == 0) begin
               if (m_stop != 0) ns = 2;
               else if (m_susp != 0) ns = 3;
               else if (m_idle != 0 && instr_done) ns = 1;
               if (reg_wr && reg_addr == 0) begin
                  nstop = reg_wdata[1];
                  ni    = reg_wdata[0] && !reg_wdata[1];
               end
               if (reg_wr && reg_addr == 1) nsu = reg_wdata[7];
            end else if (m_st == 1) begin
               if (irq_req != 0) begin ns = 0; ni = 0; end
            end else if (m_st == 3) begin
               if (wk) begin ns = 4; nsu = 0; end
            end else if (m_st == 4) begin
               if (osc_ready) ns = 0;
            end
            m_st = ns; m_idle = ni; m_stop = nstop; m_susp = nsu;
            if (m_rc > 0) m_rc = m_rc - 1;
         end
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && !finished) begin
         int exp_rd;
         exp_rd = (reg_addr == 0) ? (m_stop * 2 + m_idle) : (reg_addr == 1) ? (m_susp * 128) : 0;
         chk("R12", "mode", mode, (m_st == 4) ? 3 : m_st);
         chk("R1", "cpu_clk_en", cpu_clk_en, (m_st != 1 && m_st != 2));
         chk("R2", "periph_clk_en", periph_clk_en, m_st != 2);
         chk("R6", "timer_en", timer_en, m_st != 2);
         chk("R6", "irq_en", irq_en, m_st != 2);
         chk("R6", "mcd_en", mcd_en, 1);
         chk("R9", "intosc_en", intosc_en, !(m_st == 2 || m_st == 3));
         chk("R8", "extosc_en", extosc_en, extosc_req);
         chk("R4", "cpu_rst", cpu_rst, m_rc != 0);
         chk("R11", "reg_rdata", reg_rdata, exp_rd);
      end
   end

   task automatic step(int n = 1);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(int a, int d);
      step();
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
      step();
      reg_wr = 1'b0;
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog run did not finish");
         report();
      end
   end

   initial begin
      @(posedge clk);
      started = 1'b1;
      step(2);
      chk("R4", "reset cpu_rst", cpu_rst, 1);
      rst_n = 1'b1;
      step(6);
      chk("R12", "mode after reset", mode, 0);

      // R1 / R2: idle entry waits for retirement
      wr(0, 1);
      step(5);
      chk("R1", "mode pending idle", mode, 0);
      chk("R1", "cpu clk pending idle", cpu_clk_en, 1);
      instr_done = 1'b1; step(); instr_done = 1'b0;
      step();
      chk("R1", "mode idle", mode, 1);
      chk("R2", "periph in idle", periph_clk_en, 1);
      chk("R2", "intosc in idle", intosc_en, 1);

      // R3: interrupt ends idle
      irq_req = 4'b1000; step(); irq_req = '0;
      reg_addr = 0; step();
      chk("R3", "mode after irq", mode, 0);
      chk("R3", "idle bit cleared", reg_rdata, 0);

      // R5 / R4: watchdog
      wr(0, 1); instr_done = 1'b1; step(); instr_done = 1'b0; step();
      chk("R1", "idle again", mode, 1);
      wdt_rst = 1'b1; step(); wdt_rst = 1'b0; step(2);
      chk("R5", "wdt masked", mode, 1);
      chk("R5", "no cpu_rst", cpu_rst, 0);
      wdt_en = 1'b1; wdt_rst = 1'b1; step(); wdt_rst = 1'b0; wdt_en = 1'b0;
      step();
      chk("R4", "wdt exits idle", mode, 0);
      chk("R4", "wdt cpu_rst", cpu_rst, 1);
      step(RSTL + 1);
      chk("R4", "cpu_rst ends", cpu_rst, 0);

      // R11 / R6 / R7 / R8 / R13: stop
      wr(0, 3); reg_addr = 0; step(2);
      chk("R11", "stop wins", mode, 2);
      chk("R11", "read stop only", reg_rdata, 2);
      chk("R6", "cpu off in stop", cpu_clk_en, 0);
      irq_req = 4'b0001; usb_wake = 1'b1; osc_ready = 1'b1; step(5);
      irq_req = '0; usb_wake = 1'b0; osc_ready = 1'b0; step(2);
      chk("R7", "stop ignores wake/irq", mode, 2);
      extosc_req = 1'b1; step();
      chk("R8", "extosc follows in stop", extosc_en, 1);
      wr(0, 0); reg_addr = 0; step();
      chk("R13", "write ignored in stop", reg_rdata, 2);
      mcd_rst = 1'b1; step(); mcd_rst = 1'b0; step();
      chk("R4", "mcd reset exits stop", mode, 0);
      chk("R4", "mcd reset clears stop", reg_rdata, 0);
      step(RSTL + 1);

      // R9 / R10 / R13: suspend
      wr(1, 8'h80); step(2);
      chk("R9", "suspend mode", mode, 3);
      chk("R9", "intosc off", intosc_en, 0);
      chk("R9", "cpu runs", cpu_clk_en, 1);
      wr(0, 1); reg_addr = 0; step();
      chk("R13", "pwr write ignored in suspend", reg_rdata, 0);
      usb_wake = 1'b1; step(); usb_wake = 1'b0;
      step(4);
      reg_addr = 1; step();
      chk("R10", "still suspend code", mode, 3);
      chk("R10", "intosc back on", intosc_en, 1);
      chk("R10", "suspend bit cleared", reg_rdata, 0);
      osc_ready = 1'b1; step(); osc_ready = 1'b0; step();
      chk("R10", "run after ready", mode, 0);
      extosc_req = 1'b0; step();
      chk("R8", "extosc follows low", extosc_en, 0);

      // R4: external and internal resets end stop and pending idle
      wr(0, 2); step(2);
      chk("R6", "stop again", mode, 2);
      rst_n = 1'b0; step(2); rst_n = 1'b1; step();
      chk("R4", "rst_n exits stop", mode, 0);
      step(RSTL + 1);
      wr(0, 1); step();
      int_rst_req = 1'b1; step(); int_rst_req = 1'b0;
      instr_done = 1'b1; step(); instr_done = 1'b0; step();
      chk("R4", "int reset cancels idle", mode, 0);
      reg_addr = 0; step();
      chk("R4", "idle bit cleared by reset", reg_rdata, 0);
      step(RSTL + 2);

      finished = 1'b1;
      report();
   end

endmodule